// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between one in-order memory pipeline and a single-ported memory and gives that pipeline total-store-order behaviour. Every accepted store is parked in a small circular queue. The queue writes its entries to memory one at a time, oldest first, in any cycle where the memory port would otherwise be idle. Loads do not wait for the queue to empty. A load whose address is not held in the queue reads memory at once. A load whose address is held in the queue receives the data of the youngest held store to that address and does not touch memory.

Two ordering requests share one strobe. A fence waits until the queue has written everything to memory and then pulses a done flag. An atomic swap also waits for the queue to empty. It then reads the old word and writes the new word in two back-to-back memory cycles, with nothing in between, and returns the old word with the done pulse. While either request is in progress, the pipeline cannot issue loads or stores.

Memory reads have a latency of one cycle. Every load is answered exactly one cycle after it is accepted, so answers always come back in issue order.

Top module: `ordered_stbuf`

## Requirements
- R1: A store is accepted when `st_valid` and `st_ready` are both high. `st_ready` is low while the queue holds DEPTH entries (default 4) and while an ordering request is in progress. A refused store does not enter the queue.
- R2: Queued stores are written through the memory port (`mem_req`=1, `mem_we`=1) strictly oldest first, at most one per cycle, and only in cycles where no load read and no swap access uses the port.
- R3: An accepted load whose address matches no queued entry drives a memory read (`mem_req`=1, `mem_we`=0, `mem_addr`=`ld_addr`) in the same cycle. One cycle later it returns the memory word on `rsp_data`, even when older stores to other addresses are still queued.
- R4: An accepted load whose address matches one or more queued entries returns the data of the youngest matching entry. A store accepted in the same cycle as a load counts as younger than that load.
- R5: `rsp_valid` is high exactly in the cycle after each load acceptance and low otherwise, so responses come back in issue order.
- R6: `ord_valid` is taken only while `ld_ready` is high. With `ord_kind`=0 (fence), `ld_ready` and `st_ready` stay low until every earlier store is in memory. `ord_done` then pulses high for one cycle.
- R7: With `ord_kind`=1 (swap), the queue first empties. Memory is then read at `ord_addr` and written with `ord_wdata` in the next cycle, with no other port access in between. `ord_done` pulses with `ord_rdata` holding the old word.
- R8: After reset the queue is empty, `st_ready` and `ld_ready` are high, and `rsp_valid`, `ord_done` and `mem_req` are low.
- R9: A load or store presented in the same cycle as an accepted ordering request counts as older than that request and is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load can be accepted; no ordering request in progress |
| ld_addr | input | AW | Load word address |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | DW | Load response data |
| ord_valid | input | 1 | Ordering request strobe |
| ord_kind | input | 1 | 0 = fence, 1 = atomic swap |
| ord_addr | input | AW | Swap address |
| ord_wdata | input | DW | Swap new data |
| ord_done | output | 1 | Ordering request complete (one-cycle pulse) |
| ord_rdata | output | DW | Old word returned by a swap |
| mem_req | output | 1 | Memory port access |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after the read |

## Verification
The assertions check the following on every cycle:
- The queue never takes a store while full and never writes from an empty queue.
- A load answer always follows its acceptance by one cycle.
- A fence or swap completes only with an empty queue.
- The swap's read and write sit on adjacent cycles at one address.
- A load that misses the queue drives the memory read at once.

The bench scenarios cover what no single-cycle property can show:
- Drained writes reach memory in the order the stores were issued.
- A forwarded value comes from the youngest of several same-address entries.
- Each load returns the value that the latest store to that address in program order would leave.
- After a fence, memory agrees with that program-order view.

// File: rtl/ordered_stbuf_pkg.sv
package ordered_stbuf_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FLUSH = 2'd1,
      SEQ_RMW_R = 2'd2,
      SEQ_RMW_W = 2'd3
   } seq_state_e;

   localparam logic KIND_FENCE = 1'b0;
   localparam logic KIND_SWAP  = 1'b1;

endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [AW-1:0] ent_addr [DEPTH],
   output logic [DW-1:0] ent_data [DEPTH],
   output logic [PW-1:0] head_ptr,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_depth_bad
      $error("stbuf_queue: DEPTH must be a power of two, at least 2");
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[tail_q] <= push_addr;
         data_q[tail_q] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= tail_q + PW'(1);
         if (pop)  head_q <= head_q + PW'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ent_addr[i] = addr_q[i];
         ent_data[i] = data_q[i];
      end
   end

   assign head_ptr = head_q;
   assign count    = cnt_q;
   assign full     = (cnt_q == DEPTH_C);
   assign empty    = (cnt_q == '0);

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q != DEPTH_C));

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));

endmodule

// File: rtl/stbuf_match.sv
module stbuf_match #(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic [AW-1:0] ent_addr [DEPTH],
   input  logic [DW-1:0] ent_data [DEPTH],
   input  logic [PW-1:0] head_ptr,
   input  logic [CW-1:0] count,
   input  logic [AW-1:0] probe_addr,
   output logic          hit,
   output logic [DW-1:0] hit_data
);

   logic [PW-1:0]    age_idx [DEPTH];
   logic [DEPTH-1:0] age_hit;

   // age k = 0 is the oldest entry, k = count-1 the youngest
   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      assign age_idx[k] = head_ptr + PW'(k);
      assign age_hit[k] = (CW'(k) < count) && (ent_addr[age_idx[k]] == probe_addr);
   end

   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (age_hit[k]) begin
            hit      = 1'b1;
            hit_data = ent_data[age_idx[k]];
         end
      end
   end

endmodule

// File: rtl/stbuf_seq.sv
module stbuf_seq
   import ordered_stbuf_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_kind,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          queue_empty,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          drain_ok,
   output logic          port_req,
   output logic          port_we,
   output logic [AW-1:0] port_addr,
   output logic [DW-1:0] port_wdata,
   output logic          done,
   output logic [DW-1:0] old_data
);

   seq_state_e    state_q;
   logic          kind_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          done_q;
   logic [DW-1:0] old_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         kind_q  <= KIND_FENCE;
         addr_q  <= '0;
         wdata_q <= '0;
         done_q  <= 1'b0;
         old_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  state_q <= SEQ_FLUSH;
                  kind_q  <= req_kind;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
               end
            end
            SEQ_FLUSH: begin
               if (queue_empty) begin
                  if (kind_q == KIND_SWAP) begin
                     state_q <= SEQ_RMW_R;
                  end else begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            SEQ_RMW_R: state_q <= SEQ_RMW_W;
            SEQ_RMW_W: begin
               state_q <= SEQ_IDLE;
               done_q  <= 1'b1;
               old_q   <= mem_rdata;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != SEQ_IDLE);
   assign drain_ok   = (state_q == SEQ_IDLE) || (state_q == SEQ_FLUSH);
   assign port_req   = (state_q == SEQ_RMW_R) || (state_q == SEQ_RMW_W);
   assign port_we    = (state_q == SEQ_RMW_W);
   assign port_addr  = addr_q;
   assign port_wdata = wdata_q;
   assign done       = done_q;
   assign old_data   = old_q;

   // R7
   swap_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RMW_R) |=> (port_req && port_we && port_addr == $past(port_addr)));

   // R7
   swap_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_req |-> queue_empty);

endmodule

// File: rtl/ordered_stbuf.sv
module ordered_stbuf
   import ordered_stbuf_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic          ld_valid,
   output logic          ld_ready,
   input  logic [AW-1:0] ld_addr,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   input  logic          ord_valid,
   input  logic          ord_kind,
   input  logic [AW-1:0] ord_addr,
   input  logic [DW-1:0] ord_wdata,
   output logic          ord_done,
   output logic [DW-1:0] ord_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   if (AW < 1 || DW < 1) begin : g_width_bad
      $error("ordered_stbuf: AW and DW must be positive");
   end

   logic [AW-1:0] ent_addr [DEPTH];
   logic [DW-1:0] ent_data [DEPTH];
   logic [PW-1:0] head_ptr;
   logic [CW-1:0] q_count;
   logic          q_full, q_empty;
   logic          push, pop;

   logic          fwd_hit;
   logic [DW-1:0] fwd_data;

   logic          seq_busy, drain_ok;
   logic          seq_req, seq_we;
   logic [AW-1:0] seq_addr;
   logic [DW-1:0] seq_wdata;

   logic          ld_fire, ld_mem;
   logic          rsp_q, rsp_fwd_q;
   logic [DW-1:0] fwd_q;

   assign st_ready = !seq_busy && !q_full;
   assign ld_ready = !seq_busy;
   assign push     = st_valid && st_ready;
   assign ld_fire  = ld_valid && ld_ready;
   assign ld_mem   = ld_fire && !fwd_hit;
   assign pop      = !q_empty && drain_ok && !ld_mem;

   stbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .ent_addr  (ent_addr),
      .ent_data  (ent_data),
      .head_ptr  (head_ptr),
      .count     (q_count),
      .full      (q_full),
      .empty     (q_empty)
   );

   stbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
      .ent_addr   (ent_addr),
      .ent_data   (ent_data),
      .head_ptr   (head_ptr),
      .count      (q_count),
      .probe_addr (ld_addr),
      .hit        (fwd_hit),
      .hit_data   (fwd_data)
   );

   stbuf_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (ord_valid),
      .req_kind    (ord_kind),
      .req_addr    (ord_addr),
      .req_wdata   (ord_wdata),
      .queue_empty (q_empty),
      .mem_rdata   (mem_rdata),
      .busy        (seq_busy),
      .drain_ok    (drain_ok),
      .port_req    (seq_req),
      .port_we     (seq_we),
      .port_addr   (seq_addr),
      .port_wdata  (seq_wdata),
      .done        (ord_done),
      .old_data    (ord_rdata)
   );

   // port priority: swap access, then load read, then drain
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      if (seq_req) begin
         mem_req   = 1'b1;
         mem_we    = seq_we;
         mem_addr  = seq_addr;
         mem_wdata = seq_wdata;
      end else if (ld_mem) begin
         mem_req  = 1'b1;
         mem_addr = ld_addr;
      end else if (pop) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = ent_addr[head_ptr];
         mem_wdata = ent_data[head_ptr];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_q     <= 1'b0;
         rsp_fwd_q <= 1'b0;
         fwd_q     <= '0;
      end else begin
         rsp_q     <= ld_fire;
         rsp_fwd_q <= fwd_hit;
         fwd_q     <= fwd_data;
      end
   end

   assign rsp_valid = rsp_q;
   assign rsp_data  = rsp_fwd_q ? fwd_q : mem_rdata;

   // R5
   resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready) |=> rsp_valid);

   // R6
   fence_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_done |-> q_empty);

   // R3
   miss_reads_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && !fwd_hit) |-> (mem_req && !mem_we && mem_addr == ld_addr));

endmodule

// File: tb/ordered_stbuf_tb.sv
`timescale 1ns/1ps
module ordered_stbuf_tb;

   localparam int AW    = 8;
   localparam int DW    = 32;
   localparam int DEPTH = 4;
   localparam int NMEM  = 1 << AW;

   typedef struct packed {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } pend_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0, ld_valid = 1'b0, ord_valid = 1'b0, ord_kind = 1'b0;
   logic [AW-1:0] st_addr = '0, ld_addr = '0, ord_addr = '0;
   logic [DW-1:0] st_data = '0, ord_wdata = '0;
   logic          st_ready, ld_ready, rsp_valid, ord_done;
   logic [DW-1:0] rsp_data, ord_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   logic [DW-1:0] mem  [NMEM];
   logic [DW-1:0] arch [NMEM];
   pend_t         pend [$];

   int checks = 0, errors = 0, cyc = 0;
   bit summary_done = 0;

   logic          exp_v = 1'b0;
   logic [DW-1:0] exp_d = '0;
   string         exp_tag = "";
   logic          last_done = 1'b0, last_st_ready = 1'b0, last_ld_ready = 1'b0;
   logic [DW-1:0] last_rdata = '0;
   logic          last_st_fire = 1'b0, last_ord_fire = 1'b0;
   logic          swap_active = 1'b0, cur_kind = 1'b0;
   logic [AW-1:0] swap_addr = '0;
   logic [DW-1:0] swap_wd = '0, swap_old = '0;

   always #2.5 clk = ~clk;

   ordered_stbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
      .clk, .rst_n, .st_valid, .st_ready, .st_addr, .st_data,
      .ld_valid, .ld_ready, .ld_addr, .rsp_valid, .rsp_data,
      .ord_valid, .ord_kind, .ord_addr, .ord_wdata, .ord_done, .ord_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
      end
   endtask

   // single-ported memory model, one-cycle read latency
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata     <= mem[mem_addr];
      end
   end

   // write monitor: drained stores must appear oldest first
   always @(posedge clk) begin
      if (rst_n && mem_req && mem_we) begin
         if (pend.size() > 0) begin
            chk(mem_addr == pend[0].a && mem_wdata == pend[0].d, "R2 drain order",
                {24'd0, mem_addr, mem_wdata}, {24'd0, pend[0].a, pend[0].d});
            void'(pend.pop_front());
         end else if (swap_active) begin
            chk(mem_addr == swap_addr && mem_wdata == swap_wd, "R7 swap write",
                {24'd0, mem_addr, mem_wdata}, {24'd0, swap_addr, swap_wd});
         end else begin
            chk(1'b0, "R2 write with nothing queued", {24'd0, mem_addr, mem_wdata}, 64'd0);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

   function automatic bit queued(input logic [AW-1:0] a);
      foreach (pend[i]) if (pend[i].a == a) return 1;
      return 0;
   endfunction

   // one clock cycle: check last load answer, then drive new requests
   task automatic cycle(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input logic lv, input logic [AW-1:0] la,
                        input logic ov, input logic ok, input logic [AW-1:0] oa,
                        input logic [DW-1:0] ow);
      @(negedge clk);
      chk(rsp_valid == exp_v, "R5 response timing", {63'd0, rsp_valid}, {63'd0, exp_v});
      if (exp_v) chk(rsp_data == exp_d, exp_tag, {32'd0, rsp_data}, {32'd0, exp_d});
      last_done     = ord_done;
      last_rdata    = ord_rdata;
      last_st_ready = st_ready;
      last_ld_ready = ld_ready;
      st_valid = sv; st_addr = sa; st_data = sd;
      ld_valid = lv; ld_addr = la;
      ord_valid = ov; ord_kind = ok; ord_addr = oa; ord_wdata = ow;
      last_st_fire  = sv && st_ready;
      last_ord_fire = ov && ld_ready;
      exp_v = lv && ld_ready;
      if (exp_v) begin
         exp_d   = arch[la];
         exp_tag = queued(la) ? "R4 forwarded load data" : "R3 memory load data";
      end
      if (last_st_fire) begin
         arch[sa] = sd;
         pend.push_back('{a: sa, d: sd});
      end
      if (last_ord_fire) begin
         cur_kind = ok;
         if (ok) begin
            swap_old    = arch[oa];
            arch[oa]    = ow;
            swap_addr   = oa;
            swap_wd     = ow;
            swap_active = 1'b1;
         end
      end
   endtask

   task automatic idle();
      cycle(0, '0, '0, 0, '0, 0, 0, '0, '0);
   endtask

   task automatic wait_done();
      bit seen = 0;
      int bad  = -1;
      for (int n = 0; n < 64 && !seen; n++) begin
         idle();
         if (last_done) seen = 1;
         else chk(!last_ld_ready && !last_st_ready, "R6 requests blocked while ordering",
                  {62'd0, last_ld_ready, last_st_ready}, 64'd0);
      end
      chk(seen, "R6 ordering request completes", {63'd0, seen}, 64'd1);
      chk(pend.size() == 0, "R6 queue drained at done", pend.size(), 64'd0);
      if (cur_kind) chk(last_rdata == swap_old, "R7 swap old data", {32'd0, last_rdata}, {32'd0, swap_old});
      for (int i = 0; i < NMEM; i++) if (bad < 0 && mem[i] != arch[i]) bad = i;
      chk(bad < 0, "R6 memory matches program order at done", bad, 64'hFFFF_FFFF_FFFF_FFFF);
      swap_active = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240601));
      for (int i = 0; i < NMEM; i++) begin
         mem[i]  = 32'hA500_0000 | i;
         arch[i] = 32'hA500_0000 | i;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk(st_ready && ld_ready, "R8 readies after reset", {62'd0, st_ready, ld_ready}, 64'd3);
      chk(!rsp_valid && !ord_done && !mem_req, "R8 outputs idle after reset",
          {61'd0, rsp_valid, ord_done, mem_req}, 64'd0);

      // R1 fill: loads every cycle keep the port busy so nothing drains
      cycle(1, 8'h10, 32'h1111, 1, 8'h80, 0, 0, '0, '0);
      cycle(1, 8'h10, 32'h2222, 1, 8'h81, 0, 0, '0, '0);
      cycle(1, 8'h11, 32'h3333, 1, 8'h82, 0, 0, '0, '0);
      cycle(1, 8'h12, 32'h4444, 1, 8'h83, 0, 0, '0, '0);
      cycle(1, 8'h13, 32'h5555, 1, 8'h84, 0, 0, '0, '0);
      chk(!last_st_fire, "R1 store refused while full", {63'd0, last_st_fire}, 64'd0);
      chk(pend.size() == DEPTH, "R2 no drain while loads use port", pend.size(), DEPTH);
      // R4 youngest of two matches at 0x10
      cycle(0, '0, '0, 1, 8'h10, 0, 0, '0, '0);
      cycle(0, '0, '0, 1, 8'h11, 0, 0, '0, '0);
      // R3 miss while older stores still queued
      cycle(0, '0, '0, 1, 8'h85, 0, 0, '0, '0);
      // R4 same-cycle store is younger than the load
      cycle(1, 8'h86, 32'h6666, 1, 8'h86, 0, 0, '0, '0);
      // R6 fence, R9 same-cycle store accepted before the fence
      cycle(1, 8'h20, 32'h7777, 0, '0, 1, 0, '0, '0);
      chk(last_st_fire && last_ord_fire, "R9 store with fence accepted",
          {62'd0, last_st_fire, last_ord_fire}, 64'd3);
      wait_done();
      chk(mem[8'h20] == 32'h7777, "R9 older store visible at fence done", mem[8'h20], 64'h7777);
      // R7 swap through a queued store
      cycle(1, 8'h30, 32'hBEEF, 0, '0, 0, 0, '0, '0);
      cycle(0, '0, '0, 0, '0, 1, 1, 8'h30, 32'hCAFE);
      wait_done();
      cycle(0, '0, '0, 1, 8'h30, 0, 0, '0, '0);
      idle();

      // constrained random mix
      for (int it = 0; it < 3000; it++) begin
         logic sv, lv, ov, ok;
         logic [AW-1:0] sa, la, oa;
         sv = 1'($urandom_range(0, 1));
         lv = ($urandom_range(0, 2) != 0);
         ov = ($urandom_range(0, 40) == 0);
         ok = 1'($urandom_range(0, 1));
         sa = AW'($urandom_range(0, 7));
         la = AW'($urandom_range(0, 7));
         oa = AW'($urandom_range(0, 7));
         cycle(sv, sa, 32'($urandom), lv, la, ov, ok, oa, 32'($urandom));
         if (last_ord_fire) wait_done();
      end
      cycle(0, '0, '0, 0, '0, 1, 0, '0, '0);
      wait_done();
      idle();
      summary();
      $finish;
   end

endmodule